// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits between a host write port and a byte-wide flash array. It watches every accepted host write and works out which command is being issued. A command opens with a fixed unlock prefix: AA written to 5555, then 55 written to 2AAA. The next write selects the command:

- byte program
- chip erase
- permanent boot-region lockout
- entry to the identification mode
- exit from the identification mode

The block holds two pieces of state, the lockout flag and the identification-mode flag. It turns finished commands into requests toward the array and its timing engine. One of those requests carries the bytes to program and the other starts a chip erase. It also answers identification reads with the maker code, the device code and the lock state.

A parameter places the 16 KB boot region either at the bottom or at the top of the address space. The lockout blocks programs to that region. It also makes a chip erase spare the region. An override input lifts the lockout for as long as it is high.

Host writes arrive on a valid/ready port. Program and erase requests leave on their own valid/ready ports. A request holds its payload steady until its ready is seen. While either request is waiting, the write port drops its ready, so a new command can never overtake an unfinished one.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `wr_ready` is 1, `pgm_valid`, `ers_valid` and `id_active` are 0, and the lock reads as 0.
- R2: The writes AA@5555, 55@2AAA, A0@5555, then D@A raise `pgm_valid` on the clock edge after the write of D. The request carries `pgm_addr`=A and `pgm_data` = `old_byte` AND D, where `old_byte` is the current array content at `pgm_addr`, so a program can only clear bits.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 raise `ers_valid` on the next edge. `ers_keep_boot` is 1 exactly when the lock was set and `hv_override` was 0 during the last write.
- R4: The same six-write prefix ending in 40@5555 sets the lock. Only reset clears it.
- R5: The writes AA@5555, 55@2AAA, 90@5555 set `id_active`. It is cleared by the prefix followed by F0@5555. It is also cleared by any write of F0 to any address that neither continues a sequence nor is the data write of a program.
- R6: While `id_active` is 1, `id_data` is driven as follows. `rd_addr`=0 gives 1F. `rd_addr`=1 gives 23 when the boot region is at the bottom and 27 when it is at the top. `rd_addr`=2 gives {7'b0, lock}, with bit 0 = 1 meaning locked. Any other address gives 00. While `id_active` is 0, `id_data` is 00.
- R7: The boot region is 00000–03FFF when `TOP_BOOT`=0 and FC000–FFFFF when `TOP_BOOT`=1. A program into the region is dropped, with no request, when the lock is set and `hv_override` is 0 during the data write. While `hv_override` is 1 the program goes through.
- R8: A write that does not match the next expected cycle returns the sequencer to idle and issues nothing. The next command must start again from AA@5555.
- R9: Only address bits 14:0 are compared with 5555 and 2AAA. The upper bits are don't-care for the unlock writes.
- R10: A write handshake made while `ce_n` is 1 or `oe_n` is 0 is consumed and has no effect on any state or output.
- R11: A request held without ready keeps `pgm_addr` or `ers_keep_boot` stable. `wr_ready` stays 0 while either request is pending.
- R12: `pgm_valid` and `ers_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, low = selected |
| oe_n | input | 1 | Output enable, low blocks writes |
| hv_override | input | 1 | Lockout override, high lifts the lock |
| wr_valid | input | 1 | Host write present |
| wr_ready | output | 1 | Host write accepted when high with wr_valid |
| wr_addr | input | AW | Host write address |
| wr_data | input | 8 | Host write data |
| pgm_valid | output | 1 | Program request pending |
| pgm_ready | input | 1 | Array takes the program request |
| pgm_addr | output | AW | Byte address to program |
| pgm_data | output | 8 | Byte to store (old AND new) |
| old_byte | input | 8 | Array content at pgm_addr |
| ers_valid | output | 1 | Chip erase request pending |
| ers_ready | input | 1 | Array takes the erase request |
| ers_keep_boot | output | 1 | Erase must spare the boot region |
| id_active | output | 1 | Identification mode is on |
| rd_addr | input | AW | Read address for identification data |
| id_data | output | 8 | Identification read data |

## Verification
Two things can fall on the same clock edge: the last write of a program into the boot region, and a change of the override input. The decision to drop or pass the program must follow the override level of that very cycle. The bench provokes this by switching `hv_override` in the same cycle as the final data write, once falling and once rising. It expects no request in the falling case and a request in the rising case. A second collision is a new host write arriving while a request is still held by back-pressure. The bench judges that by checking that `wr_ready` stays low and the payload stays fixed until ready returns.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PGM_DATA,
    SQ_ERS_KEY0,
    SQ_ERS_KEY1,
    SQ_ERS_KEY2
  } seq_state_e;

  typedef struct packed {
    logic pgm;
    logic erase;
    logic lock;
    logic id_on;
    logic id_off;
  } seq_ev_t;

  localparam int    KEY_AW      = 15;
  localparam logic [KEY_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_AW-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam byte_t D_KEY1      = 8'hAA;
  localparam byte_t D_KEY2      = 8'h55;
  localparam byte_t D_PROG      = 8'hA0;
  localparam byte_t D_ERS_SETUP = 8'h80;
  localparam byte_t D_ERASE     = 8'h10;
  localparam byte_t D_LOCK      = 8'h40;
  localparam byte_t D_ID_ON     = 8'h90;
  localparam byte_t D_ID_OFF    = 8'hF0;

  localparam byte_t MFR_CODE    = 8'h1F;
  localparam byte_t DEV_BOTTOM  = 8'h23;
  localparam byte_t DEV_TOP     = 8'h27;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [KEY_AW-1:0] key_addr,
  input  byte_t             data,
  output seq_ev_t           ev
);

  seq_state_e state_q, state_d;
  logic       at_a, at_b;

  assign at_a = (key_addr == KEY_ADDR_A);
  assign at_b = (key_addr == KEY_ADDR_B);

  always_comb begin
    state_d = state_q;
    ev      = '0;
    if (acc) begin
      state_d = SQ_IDLE;
      unique case (state_q)
        SQ_IDLE:     if (at_a && data == D_KEY1) state_d = SQ_KEY1;
        SQ_KEY1:     if (at_b && data == D_KEY2) state_d = SQ_KEY2;
        SQ_KEY2: begin
          if (at_a && data == D_PROG)      state_d  = SQ_PGM_DATA;
          if (at_a && data == D_ERS_SETUP) state_d  = SQ_ERS_KEY0;
          if (at_a && data == D_ID_ON)     ev.id_on = 1'b1;
        end
        SQ_PGM_DATA: ev.pgm = 1'b1;
        SQ_ERS_KEY0: if (at_a && data == D_KEY1) state_d = SQ_ERS_KEY1;
        SQ_ERS_KEY1: if (at_b && data == D_KEY2) state_d = SQ_ERS_KEY2;
        SQ_ERS_KEY2: begin
          if (at_a && data == D_ERASE) ev.erase = 1'b1;
          if (at_a && data == D_LOCK)  ev.lock  = 1'b1;
        end
        default:     state_d = SQ_IDLE;
      endcase
      // F0 outside a program data slot never matches a sequence step,
      // so it always ends the identification mode
      if (state_q != SQ_PGM_DATA && data == D_ID_OFF) ev.id_off = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/flash_boot_gate.sv
module flash_boot_gate #(
  parameter int AW       = 20,
  parameter int BOOT_AW  = 14,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic          lock,
  input  logic          hv_override,
  output logic          in_boot,
  output logic          protect
);

  generate
    if (TOP_BOOT) begin : g_top
      assign in_boot = &addr[AW-1:BOOT_AW];
    end else begin : g_bottom
      assign in_boot = ~|addr[AW-1:BOOT_AW];
    end
  endgenerate

  assign protect = lock && !hv_override;

endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 20,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic          id_active,
  input  logic [AW-1:0] rd_addr,
  input  logic          lock,
  output byte_t         id_data
);

  localparam byte_t DEV_CODE = TOP_BOOT ? DEV_TOP : DEV_BOTTOM;

  always_comb begin
    id_data = '0;
    if (id_active) begin
      if (rd_addr == AW'(0))      id_data = MFR_CODE;
      else if (rd_addr == AW'(1)) id_data = DEV_CODE;
      else if (rd_addr == AW'(2)) id_data = {7'b0, lock};
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW         = 20,
  parameter int BOOT_BYTES = 16384,
  parameter bit TOP_BOOT   = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          hv_override,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          pgm_valid,
  input  logic          pgm_ready,
  output logic [AW-1:0] pgm_addr,
  output logic [7:0]    pgm_data,
  input  logic [7:0]    old_byte,
  output logic          ers_valid,
  input  logic          ers_ready,
  output logic          ers_keep_boot,
  output logic          id_active,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    id_data
);

  localparam int BOOT_AW = $clog2(BOOT_BYTES);

  logic          acc;
  seq_ev_t       ev;
  logic          boot_hit, protect;
  logic          pgm_valid_q, ers_valid_q, ers_keep_q;
  logic [AW-1:0] pgm_addr_q;
  byte_t         pgm_byte_q;
  logic          lock_q, id_q;

  assign wr_ready = !pgm_valid_q && !ers_valid_q;
  assign acc      = wr_valid && wr_ready && !ce_n && oe_n;

  flash_cmd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .key_addr (wr_addr[KEY_AW-1:0]),
    .data     (wr_data),
    .ev       (ev)
  );

  flash_boot_gate #(.AW(AW), .BOOT_AW(BOOT_AW), .TOP_BOOT(TOP_BOOT)) u_gate (
    .addr        (wr_addr),
    .lock        (lock_q),
    .hv_override (hv_override),
    .in_boot     (boot_hit),
    .protect     (protect)
  );

  flash_id_rom #(.AW(AW), .TOP_BOOT(TOP_BOOT)) u_id (
    .id_active (id_q),
    .rd_addr   (rd_addr),
    .lock      (lock_q),
    .id_data   (id_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgm_valid_q <= 1'b0;
      pgm_addr_q  <= '0;
      pgm_byte_q  <= '0;
      ers_valid_q <= 1'b0;
      ers_keep_q  <= 1'b0;
      lock_q      <= 1'b0;
      id_q        <= 1'b0;
    end else begin
      if (pgm_valid_q && pgm_ready) pgm_valid_q <= 1'b0;
      if (ers_valid_q && ers_ready) ers_valid_q <= 1'b0;
      // events only fire on accepted writes, i.e. with no request pending
      if (ev.pgm && !(boot_hit && protect)) begin
        pgm_valid_q <= 1'b1;
        pgm_addr_q  <= wr_addr;
        pgm_byte_q  <= wr_data;
      end
      if (ev.erase) begin
        ers_valid_q <= 1'b1;
        ers_keep_q  <= protect;
      end
      if (ev.lock)        lock_q <= 1'b1;
      if (ev.id_on)       id_q   <= 1'b1;
      else if (ev.id_off) id_q   <= 1'b0;
    end
  end

  assign pgm_valid     = pgm_valid_q;
  assign pgm_addr      = pgm_addr_q;
  assign pgm_data      = pgm_byte_q & old_byte;
  assign ers_valid     = ers_valid_q;
  assign ers_keep_boot = ers_keep_q;
  assign id_active     = id_q;

endmodule

module flash_cmd_decoder_chk #(
  parameter int AW       = 20,
  parameter int BOOT_AW  = 14,
  parameter bit TOP_BOOT = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          hv_override,
  input logic          pgm_valid,
  input logic          pgm_ready,
  input logic [AW-1:0] pgm_addr,
  input logic          ers_valid,
  input logic          ers_ready,
  input logic          ers_keep_boot,
  input logic          id_active,
  input logic [7:0]    id_data,
  input logic          lock_q
);

  logic ck_boot;
  assign ck_boot = TOP_BOOT ? (&pgm_addr[AW-1:BOOT_AW]) : (~|pgm_addr[AW-1:BOOT_AW]);

  a_r11_pgm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid && !pgm_ready |=> pgm_valid && $stable(pgm_addr));

  a_r11_ers_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ers_valid && !ers_ready |=> ers_valid && $stable(ers_keep_boot));

  a_r12_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_valid && ers_valid));

  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  a_r6_id_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !id_active |-> id_data == 8'h00);

  a_r7_boot_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_valid) && ck_boot |-> !$past(lock_q) || $past(hv_override));

  a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || !oe_n) |=> $stable(lock_q) && $stable(id_active) && !$rose(pgm_valid) && !$rose(ers_valid));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .AW(AW), .BOOT_AW(BOOT_AW), .TOP_BOOT(TOP_BOOT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ce_n          (ce_n),
  .oe_n          (oe_n),
  .hv_override   (hv_override),
  .pgm_valid     (pgm_valid),
  .pgm_ready     (pgm_ready),
  .pgm_addr      (pgm_addr),
  .ers_valid     (ers_valid),
  .ers_ready     (ers_ready),
  .ers_keep_boot (ers_keep_boot),
  .id_active     (id_active),
  .id_data       (id_data),
  .lock_q        (lock_q)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b0, oe_n = 1'b1, hv_override = 1'b0;
  logic          wr_valid = 1'b0, wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          pgm_valid, pgm_ready = 1'b1;
  logic [AW-1:0] pgm_addr;
  logic [7:0]    pgm_data, old_byte = 8'hFF;
  logic          ers_valid, ers_ready = 1'b1, ers_keep_boot;
  logic          id_active;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    id_data;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .BOOT_BYTES(16384), .TOP_BOOT(1'b0)) dut_i (.*);

  typedef struct {
    bit            is_erase;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    bit            keep;
  } exp_t;

  exp_t       q[$];
  logic [7:0] mem[int];
  logic [7:0] shadow[int];
  int         n_chk = 0, n_fail = 0;
  bit         lock_m = 0, done = 0;

  function automatic bit in_boot(input int a);
    return a < 'h4000;
  endfunction

  function automatic logic [7:0] rd_mem(input int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  function automatic logic [7:0] rd_sh(input int a);
    return shadow.exists(a) ? shadow[a] : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: array model and scoreboard
  always @(negedge clk) begin
    old_byte = rd_mem(int'(pgm_addr));
    #1;
    if (rst_n && pgm_valid && pgm_ready) begin
      if (q.size() == 0 || q[0].is_erase) chk("R2 unexpected program", {12'h0, pgm_addr}, 32'hFFFFFFFF);
      else begin
        chk("R2 program address", {12'h0, pgm_addr}, {12'h0, q[0].addr});
        chk("R2 program data", {24'h0, pgm_data}, {24'h0, q[0].data});
        void'(q.pop_front());
      end
      mem[int'(pgm_addr)] = pgm_data;
    end
    if (rst_n && ers_valid && ers_ready) begin
      if (q.size() == 0 || !q[0].is_erase) chk("R3 unexpected erase", 32'h1, 32'h0);
      else begin
        chk("R3 erase keep_boot", {31'h0, ers_keep_boot}, {31'h0, q[0].keep});
        void'(q.pop_front());
      end
      foreach (mem[k]) if (!(ers_keep_boot && in_boot(k))) mem[k] = 8'hFF;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #0.5 wr_valid = 1'b0;
  endtask

  task automatic unlock(input logic [7:0] cmd);
    wr(20'h05555, 8'hAA);
    wr(20'h02AAA, 8'h55);
    wr(20'h05555, cmd);
  endtask

  task automatic expect_pgm(input logic [AW-1:0] a, input logic [7:0] d, input bit ovr);
    exp_t e;
    if (!(in_boot(int'(a)) && lock_m && !ovr)) begin
      e.is_erase = 0; e.addr = a; e.data = rd_sh(int'(a)) & d; e.keep = 0;
      shadow[int'(a)] = e.data;
      q.push_back(e);
    end
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(8'hA0);
    expect_pgm(a, d, hv_override);
    wr(a, d);
  endtask

  // final data write changes the override in the same cycle
  task automatic prog_ovr(input logic [AW-1:0] a, input logic [7:0] d, input bit ovr);
    unlock(8'hA0);
    expect_pgm(a, d, ovr);
    @(negedge clk);
    hv_override = ovr;
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #0.5 wr_valid = 1'b0;
  endtask

  task automatic erase_cmd();
    exp_t e;
    unlock(8'h80);
    e.is_erase = 1; e.addr = '0; e.data = '0; e.keep = lock_m && !hv_override;
    foreach (shadow[k]) if (!(e.keep && in_boot(k))) shadow[k] = 8'hFF;
    q.push_back(e);
    unlock(8'h10);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic id_read(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #0.5 chk(req, {24'h0, id_data}, {24'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wr_ready", {31'h0, wr_ready}, 32'h1);
    chk("R1 pgm_valid", {31'h0, pgm_valid}, 32'h0);
    chk("R1 ers_valid", {31'h0, ers_valid}, 32'h0);
    chk("R1 id_active", {31'h0, id_active}, 32'h0);
    rst_n = 1'b1;
    id_read("R6 quiet when off", 20'h0, 8'h00);

    // R2 program and bit-clear merge
    prog(20'h12345, 8'h5A);
    settle();
    prog(20'h12345, 8'h0F);
    settle();
    chk("R2 queue drained", q.size(), 0);

    // R5/R6 identification entry, reads, exit by lone F0
    unlock(8'h90);
    settle();
    chk("R5 id entry", {31'h0, id_active}, 32'h1);
    id_read("R6 maker code", 20'h0, 8'h1F);
    id_read("R6 device code", 20'h1, 8'h23);
    id_read("R6 lock bit clear", 20'h2, 8'h00);
    id_read("R6 other address", 20'h3, 8'h00);
    wr(20'h77777, 8'hF0);
    settle();
    chk("R5 exit by lone F0", {31'h0, id_active}, 32'h0);

    // R4 lockout, read lock bit, exit via prefix F0
    prog(20'h00100, 8'h3C);
    settle();
    unlock(8'h80);
    unlock(8'h40);
    lock_m = 1;
    unlock(8'h90);
    settle();
    id_read("R4 lock bit set", 20'h2, 8'h01);
    unlock(8'hF0);
    settle();
    chk("R5 exit by prefix F0", {31'h0, id_active}, 32'h0);

    // R7 locked boot program dropped; main region still programs
    prog(20'h00200, 8'h00);
    settle();
    chk("R7 boot program dropped", {31'h0, pgm_valid}, 32'h0);
    prog(20'h04000, 8'h11);
    settle();
    hv_override = 1'b1;
    prog(20'h03FFF, 8'h22);
    settle();
    chk("R7 override lets program through", q.size(), 0);

    // same-cycle override change on the final write
    prog_ovr(20'h00300, 8'h44, 1'b0);
    settle();
    chk("R7 override fell with data write", {31'h0, pgm_valid}, 32'h0);
    prog_ovr(20'h00301, 8'h55, 1'b1);
    settle();
    hv_override = 1'b0;

    // R3 erase with lock, then with override
    erase_cmd();
    settle();
    hv_override = 1'b1;
    erase_cmd();
    settle();
    hv_override = 1'b0;
    prog(20'h00100, 8'hFF);
    settle();

    // R8 broken sequence issues nothing
    unlock(8'h77);
    wr(20'h05555, 8'hA0);
    wr(20'h56789, 8'h00);
    settle();
    chk("R8 mismatch issues nothing", {30'h0, pgm_valid, ers_valid}, 32'h0);

    // R9 upper address bits ignored for unlock writes
    wr(20'hF5555, 8'hAA);
    wr(20'h32AAA, 8'h55);
    wr(20'h85555, 8'hA0);
    expect_pgm(20'h66666, 8'h99, 1'b0);
    wr(20'h66666, 8'h99);
    settle();
    chk("R9 high bits ignored", q.size(), 0);

    // R10 writes with ce_n high / oe_n low ignored
    ce_n = 1'b1;
    wr(20'h05555, 8'hAA);
    ce_n = 1'b0;
    wr(20'h02AAA, 8'h55);
    wr(20'h05555, 8'hA0);
    wr(20'h12000, 8'h00);
    settle();
    chk("R10 ce_n high write ignored", {31'h0, pgm_valid}, 32'h0);
    oe_n = 1'b0;
    unlock(8'h90);
    oe_n = 1'b1;
    settle();
    chk("R10 oe_n low write ignored", {31'h0, id_active}, 32'h0);

    // R11 back-pressure
    pgm_ready = 1'b0;
    prog(20'h0A0A0, 8'hC3);
    settle();
    chk("R11 request held", {31'h0, pgm_valid}, 32'h1);
    chk("R11 write port stalled", {31'h0, wr_ready}, 32'h0);
    chk("R11 address held", {12'h0, pgm_addr}, 32'h0A0A0);
    chk("R12 no erase alongside", {31'h0, ers_valid}, 32'h0);
    pgm_ready = 1'b1;
    settle();
    ers_ready = 1'b0;
    erase_cmd();
    settle();
    chk("R11 erase held", {31'h0, ers_valid}, 32'h1);
    chk("R12 no program alongside", {31'h0, pgm_valid}, 32'h0);
    ers_ready = 1'b1;
    settle();

    chk("R2 R3 scoreboard empty", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule